// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM

This block is a synthesizable behavioural model of a synchronous static memory. It has a registered read path and supports bursts of four words. An access starts from one of two strobes, both active low. The processor-side strobe always starts a read. The controller-side strobe starts a read or a write, and its write inputs are sampled on the starting edge. After a cycle has started, the burst-advance input steps a separate address generator through a wrapping sequence of four addresses. That sequence is interleaved or linear, depending on a mode pin.

Each word holds two byte lanes of `BYTE_W` bits. The depth is `2**ADDR_W` words and is kept small for simulation. Writes use two controls: a global write that forces both lanes, and a byte write enable that qualifies one strobe per lane. The data output is registered. It comes with an enable flag that stands in for a tri-state driver.

There are three chip selects. The master select is active low, the second is active high and the third is active low. The master select gates only the processor-side strobe.

Top module: `sync_burst_sram`

## Requirements
- R1: While `rst_n` is low, `dout_en` is 0 and `dout` is 0.
- R2: When `pstrobe_n` is sampled low with all three selects active, the word at `addr` is placed on `dout` by the following rising edge, one cycle later, with `dout_en` high.
- R3: When `sel0_n` is high, a low `pstrobe_n` is ignored and a running burst continues. A low `cstrobe_n` is still acted on: with any select inactive it deselects the block.
- R4: On an edge where `pstrobe_n` starts a cycle, `cstrobe_n`, `gw_n`, `bwe_n` and `bsel_n` have no effect, and no write takes place.
- R5: When `cstrobe_n` is low and `pstrobe_n` is high with all selects active, a cycle starts at `addr`. A write requested on that same edge is stored at `addr`.
- R6: When `gw_n` is low on a write-capable edge, both lanes are written whatever `bwe_n` and `bsel_n` are.
- R7: When `gw_n` is high, lane i is written only if `bwe_n` and `bsel_n[i]` are both low. Lane 0 is `din[BYTE_W-1:0]` and lane 1 is the upper half. With `bwe_n` high, the edge is a read.
- R8: After any edge that writes, `dout_en` is 0, even when `oe_n` is low.
- R9: `dout_en` follows `oe_n` combinationally: it is 0 while `oe_n` is high, and `dout` keeps its value.
- R10: With `lin_mode`=0 the burst order XORs the low two address bits of the start with a step count of 0 to 3. For a start at low bits 01 this gives 01,00,11,10.
- R11: With `lin_mode`=1 the burst order adds the step count to the low two bits modulo 4. For a start at low bits 01 this gives 01,10,11,00. The upper address bits never change during a burst.
- R12: `adv_n` is ignored on the starting edge. When `adv_n` is high on a later edge, the address is held and the same word is read again.
- R13: After a deselect, the read that was already pending still appears one edge later. From the edge after that, `dout_en` stays 0 until a new cycle starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | ADDR_W | External word address |
| pstrobe_n | input | 1 | Processor-side cycle start (read), active low |
| cstrobe_n | input | 1 | Controller-side cycle start, active low |
| adv_n | input | 1 | Burst advance, active low |
| sel0_n | input | 1 | Master chip select, active low |
| sel1 | input | 1 | Chip select, active high |
| sel2_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| gw_n | input | 1 | Global write, active low |
| bwe_n | input | 1 | Byte write enable, active low |
| bsel_n | input | 2 | Per-lane write strobes, active low |
| lin_mode | input | 1 | 1 = linear burst order, 0 = interleaved |
| din | input | 2*BYTE_W | Write data |
| dout | output | 2*BYTE_W | Registered read data |
| dout_en | output | 1 | Output-driver enable flag |

## Verification
The assertions check on every cycle that:
- the output flag drops after a write edge;
- it falls after a deselect once the pipeline has drained;
- a start from the processor strobe yields valid data one edge later;
- a strobe blocked by the master select leaves an idle block idle;
- the burst generator keeps its upper bits and holds when not advanced.

Only the bench scenarios can show which word comes back, and they cover:
- the two burst orders;
- the byte-lane merging rules;
- the global-write override;
- write inputs being ignored on the processor-start edge.

// File: rtl/sbs_pkg.sv
package sbs_pkg;

    typedef enum logic [1:0] {
        EDGE_IDLE  = 2'd0,
        EDGE_BEGIN = 2'd1,
        EDGE_DESEL = 2'd2,
        EDGE_CONT  = 2'd3
    } edge_kind_e;

    // Low two address bits for step count cnt from start bits base.
    function automatic logic [1:0] burst_lo(input logic lin,
                                            input logic [1:0] base,
                                            input logic [1:0] cnt);
        return lin ? (base + cnt) : (base ^ cnt);
    endfunction

endpackage

// File: rtl/sbs_burst_gen.sv
module sbs_burst_gen #(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step,
    input  logic              linear,
    input  logic [ADDR_W-1:0] load_addr,
    output logic [ADDR_W-1:0] cur_addr
);
    import sbs_pkg::*;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [1:0]        base;
        logic [1:0]        cnt;
    } gen_t;

    gen_t st_d, st_q;
    logic [1:0] cnt_inc;

    always_comb begin
        st_d    = st_q;
        cnt_inc = st_q.cnt + 2'd1;
        if (load) begin
            st_d.addr = load_addr;
            st_d.base = load_addr[1:0];
            st_d.cnt  = 2'd0;
        end else if (step) begin
            st_d.cnt       = cnt_inc;
            st_d.addr[1:0] = burst_lo(linear, st_q.base, cnt_inc);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cur_addr = st_q.addr;

    // R11: a burst never leaves its aligned group of four
    a_r11_upper_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load) |=> cur_addr[ADDR_W-1:2] == $past(cur_addr[ADDR_W-1:2]));

    // R12: no advance, no load -> address held
    a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !load) |=> $stable(cur_addr));

endmodule

// File: rtl/sbs_lane.sv
module sbs_lane #(
    parameter int W      = 9,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [W-1:0]      wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [W-1:0]      rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem_q[waddr] <= wdata;
    end

    assign rdata = mem_q[raddr];

endmodule

// File: rtl/sync_burst_sram.sv
module sync_burst_sram #(
    parameter int BYTE_W = 9,
    parameter int ADDR_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   addr,
    input  logic                pstrobe_n,
    input  logic                cstrobe_n,
    input  logic                adv_n,
    input  logic                sel0_n,
    input  logic                sel1,
    input  logic                sel2_n,
    input  logic                oe_n,
    input  logic                gw_n,
    input  logic                bwe_n,
    input  logic [1:0]          bsel_n,
    input  logic                lin_mode,
    input  logic [2*BYTE_W-1:0] din,
    output logic [2*BYTE_W-1:0] dout,
    output logic                dout_en
);
    import sbs_pkg::*;

    localparam int LANES  = 2;
    localparam int WORD_W = LANES * BYTE_W;

    typedef struct packed {
        logic              active;
        logic              vld;
        logic [WORD_W-1:0] data;
    } pipe_t;

    pipe_t       st_d, st_q;
    edge_kind_e  kind;
    logic        sel_all, p_start, c_start, do_write;
    logic [LANES-1:0]  wmask, lane_we;
    logic [ADDR_W-1:0] gen_addr, wr_addr;
    logic [WORD_W-1:0] rd_word;

    always_comb begin
        sel_all = !sel0_n && sel1 && !sel2_n;
        p_start = !pstrobe_n && !sel0_n;
        c_start = !cstrobe_n && pstrobe_n;

        if (p_start || c_start) kind = sel_all ? EDGE_BEGIN : EDGE_DESEL;
        else if (st_q.active)   kind = EDGE_CONT;
        else                    kind = EDGE_IDLE;

        if (!gw_n)       wmask = '1;
        else if (!bwe_n) wmask = ~bsel_n;
        else             wmask = '0;

        do_write = ((kind == EDGE_BEGIN && c_start) || kind == EDGE_CONT)
                   && (wmask != '0);
        lane_we  = do_write ? wmask : '0;
        wr_addr  = (kind == EDGE_BEGIN) ? addr : gen_addr;

        st_d = st_q;
        if (kind == EDGE_BEGIN)      st_d.active = 1'b1;
        else if (kind == EDGE_DESEL) st_d.active = 1'b0;

        if (do_write) begin
            st_d.vld = 1'b0;
        end else if (st_q.active) begin
            st_d.vld  = 1'b1;
            st_d.data = rd_word;
        end else begin
            st_d.vld = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    sbs_burst_gen #(.ADDR_W(ADDR_W)) u_gen (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (kind == EDGE_BEGIN),
        .step      (kind == EDGE_CONT && !adv_n),
        .linear    (lin_mode),
        .load_addr (addr),
        .cur_addr  (gen_addr)
    );

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        sbs_lane #(.W(BYTE_W), .ADDR_W(ADDR_W)) u_lane (
            .clk   (clk),
            .we    (lane_we[i]),
            .waddr (wr_addr),
            .wdata (din[i*BYTE_W +: BYTE_W]),
            .raddr (gen_addr),
            .rdata (rd_word[i*BYTE_W +: BYTE_W])
        );
    end

    assign dout    = st_q.data;
    assign dout_en = st_q.vld && !oe_n;

    // R8: a write edge blanks the output
    a_r8_write_blanks: assert property (@(posedge clk) disable iff (!rst_n)
        do_write |=> !dout_en);

    // R13: output drains after deselect
    a_r13_drain: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == EDGE_DESEL) ##1 (kind != EDGE_BEGIN) |=> !st_q.vld);

    // R2: processor start gives data one edge later
    a_r2_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (p_start && sel_all) ##1 !do_write |=> st_q.vld);

    // R3: master select blocks the processor strobe
    a_r3_master_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.active && !pstrobe_n && sel0_n) |=> !st_q.active);

endmodule

// File: tb/sync_burst_sram_test.sv
module sync_burst_sram_test;
    localparam int BW = 9;
    localparam int AW = 8;
    localparam int WW = 2 * BW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [AW-1:0] addr;
    logic pstrobe_n, cstrobe_n, adv_n, sel0_n, sel1, sel2_n, oe_n;
    logic gw_n, bwe_n, lin_mode;
    logic [1:0] bsel_n;
    logic [WW-1:0] din, dout;
    logic dout_en;

    int n_checks = 0;
    int n_fail = 0;
    logic [WW-1:0] model [256];

    always #2 clk = ~clk;

    sync_burst_sram #(.BYTE_W(BW), .ADDR_W(AW)) uut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .pstrobe_n(pstrobe_n),
        .cstrobe_n(cstrobe_n), .adv_n(adv_n), .sel0_n(sel0_n), .sel1(sel1),
        .sel2_n(sel2_n), .oe_n(oe_n), .gw_n(gw_n), .bwe_n(bwe_n),
        .bsel_n(bsel_n), .lin_mode(lin_mode), .din(din), .dout(dout),
        .dout_en(dout_en)
    );

    task automatic check(input bit ok, input string req,
                         input logic [WW-1:0] act, input logic [WW-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic defaults();
        addr = '0; pstrobe_n = 1; cstrobe_n = 1; adv_n = 1;
        sel0_n = 0; sel1 = 1; sel2_n = 0; oe_n = 0;
        gw_n = 1; bwe_n = 1; bsel_n = 2'b11; din = '0;
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic cwrite(input logic [AW-1:0] a, input logic [WW-1:0] d);
        cstrobe_n = 0; addr = a; gw_n = 0; din = d;
        tick();
        model[a] = d;
        defaults();
    endtask

    task automatic deselect();
        cstrobe_n = 0; sel1 = 0;
        tick();
        defaults();
        tick();
    endtask

    task automatic start_read(input logic [AW-1:0] a, input logic lin);
        pstrobe_n = 0; addr = a; lin_mode = lin; adv_n = 0;
        tick();
        defaults();
    endtask

    task automatic t_reset();
        check(dout_en == 1'b0, "R1 reset dout_en", {17'd0, dout_en}, '0);
        check(dout == '0, "R1 reset dout", dout, '0);
    endtask

    task automatic t_preload();
        for (int i = 0; i < 16; i++) cwrite(AW'(8'h10 + i), WW'(18'h01000 + i * 18'h00523));
        cwrite(8'h05, 18'h15A5A);
        deselect();
    endtask

    task automatic t_read_latency();
        start_read(8'h14, 1'b1);
        check(dout_en == 1'b0, "R2 no data on start edge", {17'd0, dout_en}, '0);
        tick();
        check(dout_en && dout == model[8'h14], "R2 read data", dout, model[8'h14]);
        tick();
        check(dout == model[8'h14], "R12 hold address", dout, model[8'h14]);
        oe_n = 1; #1;
        check(dout_en == 1'b0, "R9 oe high blanks", {17'd0, dout_en}, '0);
        check(dout == model[8'h14], "R9 data kept", dout, model[8'h14]);
        oe_n = 0;
        deselect();
    endtask

    task automatic t_burst(input logic lin);
        logic [1:0] lo;
        start_read(8'h11, lin);
        adv_n = 0; lin_mode = lin;
        for (int j = 0; j < 4; j++) begin
            tick();
            lo = lin ? 2'(2'b01 + j) : (2'b01 ^ 2'(j));
            check(dout_en && dout == model[{6'b000100, lo}],
                  lin ? "R11 linear order" : "R10 interleaved order",
                  dout, model[{6'b000100, lo}]);
        end
        defaults();
        deselect();
    endtask

    task automatic t_master_and_drain();
        start_read(8'h18, 1'b1);
        tick();
        check(dout == model[8'h18], "R3 burst running", dout, model[8'h18]);
        pstrobe_n = 0; addr = 8'h1A; sel0_n = 1; adv_n = 0; lin_mode = 1;
        tick();
        defaults();
        tick();
        check(dout == model[8'h19], "R3 blocked strobe ignored", dout, model[8'h19]);
        cstrobe_n = 0; sel0_n = 1;
        tick();
        defaults();
        check(dout_en == 1'b1, "R13 pending read drains", {17'd0, dout_en}, 18'd1);
        tick();
        check(dout_en == 1'b0, "R3 R13 deselected by cstrobe", {17'd0, dout_en}, '0);
        tick();
        check(dout_en == 1'b0, "R13 stays off", {17'd0, dout_en}, '0);
    endtask

    task automatic t_byte_writes();
        logic [WW-1:0] exp;
        pstrobe_n = 0; cstrobe_n = 0; gw_n = 0; bwe_n = 0; bsel_n = 2'b00;
        din = 18'h3FFFF; addr = 8'h1C;
        tick();
        defaults();
        tick();
        check(dout == model[8'h1C], "R4 write ignored on start edge", dout, model[8'h1C]);
        bwe_n = 0; bsel_n = 2'b10; din = 18'h2AA55;
        tick();
        check(dout_en == 1'b0, "R8 write blanks output", {17'd0, dout_en}, '0);
        exp = {model[8'h1C][WW-1:BW], din[BW-1:0]};
        model[8'h1C] = exp;
        defaults();
        tick();
        check(dout_en && dout == exp, "R7 lane0 only", dout, exp);
        bwe_n = 1; bsel_n = 2'b00; din = 18'h00F0F;
        tick();
        defaults();
        tick();
        check(dout_en && dout == model[8'h1C], "R7 bwe high no write", dout, model[8'h1C]);
        gw_n = 0; bwe_n = 1; bsel_n = 2'b11; din = 18'h1234B;
        tick();
        check(dout_en == 1'b0, "R8 global write blanks", {17'd0, dout_en}, '0);
        model[8'h1C] = 18'h1234B;
        defaults();
        tick();
        check(dout == 18'h1234B, "R6 global write both lanes", dout, 18'h1234B);
        deselect();
    endtask

    task automatic t_ctrl_write();
        logic [WW-1:0] d;
        cstrobe_n = 0; addr = 8'h05; bwe_n = 0; bsel_n = 2'b01; d = 18'h0C3C3; din = d;
        tick();
        model[8'h05] = {d[WW-1:BW], model[8'h05][BW-1:0]};
        defaults();
        deselect();
        start_read(8'h05, 1'b1);
        tick();
        check(dout == model[8'h05], "R5 controller lane1 write", dout, model[8'h05]);
        deselect();
    endtask

    initial begin
        #(4 * 150000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual running expected done");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        defaults();
        lin_mode = 1;
        @(negedge clk);
        @(negedge clk);
        t_reset();
        rst_n = 1;
        tick();
        t_preload();
        t_read_latency();
        t_burst(1'b0);
        t_burst(1'b1);
        t_master_and_drain();
        t_byte_writes();
        t_ctrl_write();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule